// File: doc/BRIEF.md
# Non-volatile Commit Sequencer

This block decides whether a setting that has just arrived over a serial link gets written into non-volatile storage, and it times that write. The serial front end raises a one-cycle completion strobe together with the received byte. The sequencer keeps the byte as a pending value for a short time. It starts a write only if the program request is high at the first clock edge after the strobe cycle. If the request is absent at that edge, the pending byte is dropped two cycles after it arrived, and a later request cannot commit it.

While a write is in progress, the block raises a busy signal that tells the serial logic to ignore its input and leave its output undriven. It also holds ready low. The erase/write time is a parameterised number of serial-clock cycles, and the count advances only while the clock runs. A supply-OK flag from a low-voltage detector gates the ready output on every cycle. If the supply drops at any point during a write, the write is abandoned and ready stays low afterwards, which marks the failure. When a write completes cleanly, a one-cycle write command carries the byte to the storage model.

Top module: `nvs_commit_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, rdy, busy and wr_cmd are 0 and wr_data is 0.
- R2: A program request that is high at the clock edge right after the frame_done cycle starts a write. From the next cycle, busy is 1 and rdy is 0.
- R3: A program request at any other edge does not start a write. This covers the strobe edge itself, the second edge after it, and any edge with no frame. The pending byte is dropped two cycles after the strobe.
- R4: Once a write starts, busy stays high for exactly EW_CYCLES consecutive cycles.
- R5: If supply_ok stays high on every edge from the start to the end of the write, wr_cmd is 1 for exactly the one cycle after busy falls, and wr_data holds the byte received in the starting frame.
- R6: If supply_ok is low on any edge during a write, no wr_cmd is issued. After the write, rdy stays low until the next write starts, even if the supply has recovered.
- R7: rdy is registered. It is 1 only when the supply_ok sampled at the previous edge was high, no write is in progress, and the last write did not fail. A low supply_ok forces rdy low in the next cycle.
- R8: A frame strobe or program request that arrives while busy is ignored. Nothing is queued, so no second write follows the current one.
- R9: A newer frame replaces the pending byte. The write commits the byte of the frame whose window held the request.
- R10: wr_data stays constant while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all progress is counted on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: a complete setting has been received |
| rx_data | input | DATA_W | Received setting, valid with frame_done |
| prog_req | input | 1 | Program request, sampled at the edge after the strobe cycle |
| supply_ok | input | 1 | High while the supply is fit for programming |
| rdy | output | 1 | High = ready; low = busy, supply low or last write failed |
| busy | output | 1 | Write in progress; serial input ignored, data out undriven |
| wr_cmd | output | 1 | One-cycle commit strobe toward the storage model |
| wr_data | output | DATA_W | Setting to store |

## Verification
On every cycle, the assertions check the following:
- the busy run length;
- that ready is low while busy and after a low supply;
- that a write starts only two edges after a strobe with the request at the edge between;
- that the commit pulse is single and falls only at the end of busy;
- that the data is stable during a write.

Only the bench scenarios can show the following:
- that a late or early request is dropped;
- that a newer frame wins;
- that a supply dip leaves ready stuck low until the next write;
- that requests made during a write are not queued.

The cycle-by-cycle model covers those scenarios on every clock.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    AGE_NONE  = 2'd0,
    AGE_FRESH = 2'd1,
    AGE_STALE = 2'd2
  } hold_age_t;
endpackage

// File: rtl/nvs_hold.sv
module nvs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              window_o
);
  import nvs_pkg::*;

  hold_age_t         age_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q  <= AGE_NONE;
      data_q <= '0;
    end else if (clr_i) begin
      age_q <= AGE_NONE;
    end else if (load_i) begin
      age_q  <= AGE_FRESH;
      data_q <= data_i;
    end else begin
      case (age_q)
        AGE_FRESH: age_q <= AGE_STALE;
        AGE_STALE: age_q <= AGE_NONE;
        default:   age_q <= AGE_NONE;
      endcase
    end
  end

  assign data_o   = data_q;
  assign window_o = (age_q == AGE_FRESH);
endmodule

// File: rtl/nvs_ewtimer.sv
module nvs_ewtimer #(
  parameter int EW_CYCLES = 4000,
  localparam int CNT_W = (EW_CYCLES > 2) ? $clog2(EW_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic end_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(EW_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign end_o  = busy_q && (cnt_q == '0);
endmodule

// File: rtl/nvs_status.sv
module nvs_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              busy_i,
  input  logic              sup_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rdy_o,
  output logic              wr_cmd_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              facc_q;
  logic              fail_q;
  logic              rdy_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic              busy_nx;
  logic              commit_ok;
  logic              fail_nx;

  always_comb begin
    busy_nx   = start_i | (busy_i & ~end_i);
    commit_ok = end_i & ~facc_q & sup_i;
    if (start_i)                 fail_nx = 1'b0;
    else if (end_i & ~commit_ok) fail_nx = 1'b1;
    else                         fail_nx = fail_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      facc_q <= 1'b0;
      fail_q <= 1'b0;
      rdy_q  <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      wr_q   <= commit_ok;
      fail_q <= fail_nx;
      rdy_q  <= sup_i & ~busy_nx & ~fail_nx;
      if (start_i) begin
        wd_q   <= data_i;
        facc_q <= ~sup_i;
      end else if (busy_i & ~sup_i) begin
        facc_q <= 1'b1;
      end
    end
  end

  assign rdy_o     = rdy_q;
  assign wr_cmd_o  = wr_q;
  assign wr_data_o = wd_q;
endmodule

// File: rtl/nvs_commit_seq.sv
module nvs_commit_seq #(
  parameter int DATA_W    = 8,
  parameter int EW_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              prog_req,
  input  logic              supply_ok,
  output logic              rdy,
  output logic              busy,
  output logic              wr_cmd,
  output logic [DATA_W-1:0] wr_data
);
  logic              window;
  logic              start;
  logic              load;
  logic              ew_end;
  logic [DATA_W-1:0] hold_data;

  assign start = window & prog_req & ~busy;
  assign load  = frame_done & ~busy & ~start;

  nvs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load_i(load), .clr_i(start),
    .data_i(rx_data), .data_o(hold_data), .window_o(window)
  );

  nvs_ewtimer #(.EW_CYCLES(EW_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .end_o(ew_end)
  );

  nvs_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .start_i(start), .end_i(ew_end), .busy_i(busy),
    .sup_i(supply_ok), .data_i(hold_data), .rdy_o(rdy), .wr_cmd_o(wr_cmd),
    .wr_data_o(wr_data)
  );
endmodule

// File: rtl/nvs_commit_seq_chk.sv
module nvs_commit_seq_chk #(
  parameter int DATA_W    = 8,
  parameter int EW_CYCLES = 4000
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_done,
  input logic              prog_req,
  input logic              supply_ok,
  input logic              rdy,
  input logic              busy,
  input logic              wr_cmd,
  input logic [DATA_W-1:0] wr_data
);
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < EW_CYCLES));
  p_busy_full_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == EW_CYCLES));
  p_start_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(prog_req));
  p_start_frame_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_done, 2));
  p_rdy_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rdy);
  p_rdy_supply_r7: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !rdy);
  p_cmd_end_r5: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |-> ($past(busy) && !busy));
  p_cmd_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> !wr_cmd);
  p_cmd_supply_r6: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |-> $past(supply_ok));
  p_data_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wr_data));
endmodule

bind nvs_commit_seq nvs_commit_seq_chk #(.DATA_W(DATA_W), .EW_CYCLES(EW_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .frame_done(frame_done), .prog_req(prog_req),
  .supply_ok(supply_ok), .rdy(rdy), .busy(busy), .wr_cmd(wr_cmd), .wr_data(wr_data)
);

// File: tb/nvs_commit_seq_bench.sv
module nvs_commit_seq_bench;
  localparam int DW = 8;
  localparam int EW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_done = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic prog_req = 1'b0;
  logic supply_ok = 1'b1;
  logic rdy, busy, wr_cmd;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nvs_commit_seq #(.DATA_W(DW), .EW_CYCLES(EW)) u_nvs_commit_seq (
    .clk(clk), .rst(rst), .frame_done(frame_done), .rx_data(rx_data),
    .prog_req(prog_req), .supply_ok(supply_ok), .rdy(rdy), .busy(busy),
    .wr_cmd(wr_cmd), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_age, m_cnt;
  bit m_busy, m_fail, m_facc, m_rdy, m_wr, m_valid;
  int m_hold, m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_age = 0; m_cnt = 0; m_busy = 0; m_fail = 0; m_facc = 0;
      m_rdy = 0; m_wr = 0; m_hold = 0; m_data = 0;
    end else begin
      bit was_busy, go;
      was_busy = m_busy;
      go = (m_age == 1) && prog_req && !was_busy;
      m_wr = 0;
      if (was_busy) begin
        if (!supply_ok) m_facc = 1;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (!m_facc && supply_ok) m_wr = 1; else m_fail = 1;
        end else m_cnt--;
      end else if (go) begin
        m_busy = 1; m_cnt = EW - 1; m_data = m_hold;
        m_facc = !supply_ok; m_fail = 0;
      end
      if (go) m_age = 0;
      else if (frame_done && !was_busy) begin m_hold = rx_data; m_age = 1; end
      else if (m_age == 1) m_age = 2;
      else m_age = 0;
      m_rdy = supply_ok && !m_busy && !m_fail;
    end
    m_valid = 1;
  end

  // per-cycle comparison and event log
  int run_len = 0, last_len = 0, n_wr = 0, n_start = 0, last_wd = 0;
  bit prev_busy = 0;
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk(rdy == m_rdy, "R7 rdy", rdy, m_rdy);
      chk(busy == m_busy, "R4 busy", busy, m_busy);
      chk(wr_cmd == m_wr, "R5 wr_cmd", wr_cmd, m_wr);
      chk(int'(wr_data) == m_data, "R10 wr_data", wr_data, m_data);
    end
    if (!rst) begin
      if (busy && !prev_busy) n_start++;
      if (busy) run_len++;
      else if (run_len > 0) begin last_len = run_len; run_len = 0; end
      if (wr_cmd) begin n_wr++; last_wd = wr_data; end
    end
    prev_busy = busy;
  end

  // prog_at: -1 none, 0 during strobe cycle, 1 window edge, 2 one edge late
  task automatic frame(input int d, input int prog_at);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      frame_done = (i == 0);
      rx_data = DW'(d);
      prog_req = (i == prog_at);
    end
    @(negedge clk);
    frame_done = 0; prog_req = 0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int s, w;
    repeat (3) @(negedge clk);
    chk(rdy == 0 && busy == 0 && wr_cmd == 0 && wr_data == 0, "R1 reset outputs", {rdy, busy, wr_cmd}, 0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && wr_cmd == 0, "R1 first cycle", {busy, wr_cmd}, 0);
    @(negedge clk);
    chk(rdy == 1, "R7 ready idle", rdy, 1);

    // R2 / R5 nominal write
    frame(8'hA5, 1);
    chk(busy == 1 && rdy == 0, "R2 busy after request", {busy, rdy}, 2);
    settle();
    chk(n_wr == 1, "R5 commit count", n_wr, 1);
    chk(last_wd == 8'hA5, "R5 commit data", last_wd, 8'hA5);
    chk(last_len == EW, "R4 busy length", last_len, EW);
    chk(rdy == 1, "R5 ready after success", rdy, 1);

    // R3 requests outside the window
    s = n_start;
    frame(8'h3C, 2); settle();
    chk(n_start == s, "R3 late request", n_start, s);
    frame(8'h3C, 0); settle();
    chk(n_start == s, "R3 request at strobe edge", n_start, s);
    @(negedge clk); prog_req = 1; repeat (3) @(negedge clk); prog_req = 0;
    repeat (2) @(negedge clk);
    chk(n_start == s, "R3 request without frame", n_start, s);

    // R9 newer frame wins
    frame(8'h11, -1);
    frame(8'h77, 1); settle();
    chk(last_wd == 8'h77, "R9 newer frame committed", last_wd, 8'h77);

    // R6 supply dip during write
    w = n_wr;
    frame(8'hC3, 1);
    repeat (3) @(negedge clk);
    supply_ok = 0; repeat (2) @(negedge clk); supply_ok = 1;
    settle();
    chk(n_wr == w, "R6 no commit on dip", n_wr, w);
    repeat (5) @(negedge clk);
    chk(rdy == 0, "R6 ready stuck low", rdy, 0);
    frame(8'h5A, 1); settle();
    chk(n_wr == w + 1 && last_wd == 8'h5A, "R6 recovery write", last_wd, 8'h5A);
    chk(rdy == 1, "R6 ready restored", rdy, 1);

    // R7 idle supply drop
    @(negedge clk); supply_ok = 0;
    @(negedge clk);
    chk(rdy == 0, "R7 ready follows supply", rdy, 0);
    supply_ok = 1;
    @(negedge clk);
    chk(rdy == 1, "R7 ready returns", rdy, 1);

    // R8 requests while busy
    s = n_start;
    frame(8'h96, 1);
    frame(8'h69, 1);
    settle(); repeat (6) @(negedge clk);
    chk(n_start == s + 1, "R8 no queued write", n_start, s + 1);
    chk(last_wd == 8'h96, "R8 first data kept", last_wd, 8'h96);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule